// File: doc/BRIEF.md
# Exception Entry and Status Controller

This block holds a processor's current status word and one saved copy of it for each exception mode. It also holds a link register per mode bank. Requests for reset, undefined instruction, software interrupt, prefetch abort, data abort, IRQ and FIQ arrive on separate lines. On a clock edge where at least one usable request is present, the block performs the whole entry in that single edge:

- the current status goes into the saved register of the target mode;
- the supplied return link goes into that mode's link register;
- the mode field, the instruction-state bit and the interrupt masks are rewritten;
- a vector address is produced from a low or a high table base.

Outside of exception entry, privileged software can rewrite the status word or the saved status of the current mode through a simple write port. The block guards the control byte against writes made in user mode. It also refuses any saved-status access in the two modes that have no saved register.

The outputs are the live status word, the saved status of the current mode, the link register of the current mode, the last vector address and a one-cycle entry strobe. These outputs let the surrounding pipeline redirect fetch and let a return path restore state later. Decode, pipeline flushing and the return sequence itself are left to other blocks.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On entry, the saved status of the target mode takes the status word from before the entry, and the target mode's link register takes `ret_link`. Both are readable while that mode is current.
- R2: On entry, status bits [4:0] take the target mode code and bit 5 is cleared. The mode codes are user 0b10000, FIQ 0b10001, IRQ 0b10010, supervisor 0b10011, abort 0b10111, undefined 0b11011 and system 0b11111. Reset and software interrupt enter supervisor mode. Both aborts enter abort mode. An undefined instruction enters undefined mode.
- R3: On entry, bit 7 (IRQ mask) is always set. Bit 6 (FIQ mask) is set for reset and FIQ and keeps its previous value for every other exception.
- R4: `new_pc` is the table base plus an offset. The base is 0x00000000, or 0xFFFF0000 when `hivec_sel` is 1. The offsets are reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C. Offset 0x14 is never produced.
- R5: Simultaneous requests are served in this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R6: An IRQ request is ignored while bit 7 is set, and an FIQ request is ignored while bit 6 is set. An ignored request leaves every output unchanged.
- R7: In user and system modes, `saved_invalid` is 1 and `saved_word` reads 0. A saved-status write in those modes changes no stored saved status.
- R8: A status write in a privileged mode replaces the whole word. A status write in user mode changes only bits [31:8] and keeps bits [7:0].
- R9: After reset the status word is 0x000000D3 and all saved and link registers and `new_pc` are 0. `entry_stb` is high in the cycle after each edge at which an entry is taken, and `new_pc` and the status take their new values in that same cycle. An entry on the same edge as a software write wins, and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| ret_link | input | 32 | Return link saved on entry |
| hivec_sel | input | 1 | 1 selects the high vector table |
| sw_wr_en | input | 1 | Software status write strobe |
| sw_wr_saved | input | 1 | 1 targets the saved status, 0 the current status |
| sw_wr_data | input | 32 | Software write data |
| status_word | output | 32 | Current status word |
| saved_word | output | 32 | Saved status of the current mode (0 if none) |
| saved_invalid | output | 1 | Current mode has no saved status |
| mode_link | output | 32 | Link register of the current mode |
| new_pc | output | 32 | Vector address of the latest entry |
| entry_stb | output | 1 | One-cycle strobe after an entry |

## Verification
A wrong mode field or a wrong mask bit shows on `status_word` in the cycle right after the entry edge. Because later entries save that word, the error also shows one entry later on `saved_word`. A misrouted saved or link write only shows when the affected mode becomes current again, which can be many cycles later. For that reason the bench compares every output against its model on every cycle and deliberately returns to modes it has already visited. A priority or masking fault shows at once as a wrong `new_pc` or a missing `entry_stb`.

// File: rtl/exc_ctrl_pkg.sv
// Shared constants, types and helper functions for the exception controller.
// Assumes a 32-bit status word with the control byte in bits [7:0].
package exc_ctrl_pkg;

    localparam int STATUS_W  = 32;
    localparam int MODE_W    = 5;
    localparam int BIT_T     = 5;
    localparam int BIT_F     = 6;
    localparam int BIT_I     = 7;
    localparam int NUM_KINDS = 8;
    localparam int NUM_BANKS = 6;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    // Encoding equals vector offset / 4; value 5 is the reserved slot.
    typedef enum logic [2:0] {
        EK_RESET = 3'd0,
        EK_UNDEF = 3'd1,
        EK_SWI   = 3'd2,
        EK_PABT  = 3'd3,
        EK_DABT  = 3'd4,
        EK_RSVD  = 3'd5,
        EK_IRQ   = 3'd6,
        EK_FIQ   = 3'd7
    } exc_kind_e;

    typedef logic [BANK_W-1:0] bank_t;

    // Bank 0 is the shared user/system bank, which has no saved status.
    function automatic bank_t bank_of(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: return bank_t'(1);
            MODE_IRQ: return bank_t'(2);
            MODE_SVC: return bank_t'(3);
            MODE_ABT: return bank_t'(4);
            MODE_UND: return bank_t'(5);
            default:  return bank_t'(0);
        endcase
    endfunction

    function automatic logic [MODE_W-1:0] mode_for(input exc_kind_e k);
        case (k)
            EK_FIQ:           return MODE_FIQ;
            EK_IRQ:           return MODE_IRQ;
            EK_PABT, EK_DABT: return MODE_ABT;
            EK_UNDEF:         return MODE_UND;
            default:          return MODE_SVC;
        endcase
    endfunction

    function automatic logic sets_fiq_mask(input exc_kind_e k);
        return (k == EK_RESET) || (k == EK_FIQ);
    endfunction

endpackage

// File: rtl/exc_req_arbiter.sv
// Fixed-priority selection among exception requests.
// Assumes req is indexed by exc_kind_e; IRQ and FIQ are dropped while masked.
module exc_req_arbiter
    import exc_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_KINDS-1:0] req,
    input  logic                 irq_masked,
    input  logic                 fiq_masked,
    output logic                 grant_vld,
    output exc_kind_e            grant_kind
);

    localparam int NUM_PRIO = 7;
    // Highest priority first.
    localparam logic [2:0] PRIO [NUM_PRIO] = '{
        3'(EK_RESET), 3'(EK_DABT), 3'(EK_FIQ), 3'(EK_IRQ),
        3'(EK_PABT), 3'(EK_UNDEF), 3'(EK_SWI)
    };

    logic [NUM_KINDS-1:0] eligible;
    logic [NUM_KINDS-1:0] grant_vec;

    // Remove masked interrupt requests and the reserved slot.
    always_comb begin
        eligible          = req;
        eligible[EK_RSVD] = 1'b0;
        if (irq_masked) eligible[EK_IRQ] = 1'b0;
        if (fiq_masked) eligible[EK_FIQ] = 1'b0;
    end

    // Walk lowest to highest priority so the highest eligible wins.
    always_comb begin
        grant_vld  = 1'b0;
        grant_kind = EK_RESET;
        grant_vec  = '0;
        for (int i = NUM_PRIO - 1; i >= 0; i--) begin
            if (eligible[PRIO[i]]) begin
                grant_vld           = 1'b1;
                grant_kind          = exc_kind_e'(PRIO[i]);
                grant_vec           = '0;
                grant_vec[PRIO[i]]  = 1'b1;
            end
        end
    end

    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));
    a_r5_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        req[EK_RESET] |-> (grant_vld && grant_kind == EK_RESET));
    a_r6_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_masked && grant_vld) |-> (grant_kind != EK_IRQ));
    a_r6_fiq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_masked && grant_vld) |-> (grant_kind != EK_FIQ));

endmodule

// File: rtl/exc_vector_gen.sv
// Forms the vector address from the table base and the exception kind.
// Assumes the kind encoding equals offset / 4.
module exc_vector_gen
    import exc_ctrl_pkg::*;
#(
    parameter int                AW        = 32,
    parameter logic [AW-1:0]     LOW_BASE  = 32'h0000_0000,
    parameter logic [AW-1:0]     HIGH_BASE = 32'hFFFF_0000
) (
    input  exc_kind_e       kind,
    input  logic            hivec,
    output logic [AW-1:0]   addr
);

    localparam int OFF_W = $clog2(NUM_KINDS) + 2;

    logic [OFF_W-1:0] offset;

    // Offset is the kind scaled to a word address.
    always_comb offset = {kind, 2'b00};

    // Base choice plus offset.
    always_comb addr = (hivec ? HIGH_BASE : LOW_BASE) + {{(AW-OFF_W){1'b0}}, offset};

endmodule

// File: rtl/exc_mode_bank.sv
// Per-mode saved status and link storage.
// Assumes bank 0 is the user/system bank with a link register but no saved status.
module exc_mode_bank
    import exc_ctrl_pkg::*;
#(
    parameter int W  = 32,
    parameter int NB = NUM_BANKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter,
    input  bank_t         enter_bank,
    input  logic [W-1:0]  enter_status,
    input  logic [W-1:0]  enter_link,
    input  logic          sw_wr,
    input  bank_t         sw_bank,
    input  logic [W-1:0]  sw_data,
    input  bank_t         rd_bank,
    output logic [W-1:0]  rd_saved,
    output logic [W-1:0]  rd_link
);

    logic [W-1:0] saved_q [NB];
    logic [W-1:0] link_q  [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        // Link register: written on entry into this bank.
        always_ff @(posedge clk) begin
            if (!rst_n)                              link_q[b] <= '0;
            else if (enter && enter_bank == bank_t'(b)) link_q[b] <= enter_link;
        end

        if (b == 0) begin : g_no_saved
            assign saved_q[b] = '0;
        end else begin : g_saved
            // Saved status: entry has priority over a software write.
            always_ff @(posedge clk) begin
                if (!rst_n)                                 saved_q[b] <= '0;
                else if (enter && enter_bank == bank_t'(b)) saved_q[b] <= enter_status;
                else if (sw_wr && sw_bank == bank_t'(b))    saved_q[b] <= sw_data;
            end
        end
    end

    // Read ports for the current bank.
    always_comb begin
        rd_saved = (int'(rd_bank) < NB) ? saved_q[rd_bank] : '0;
        rd_link  = (int'(rd_bank) < NB) ? link_q[rd_bank]  : '0;
    end

    a_r7_no_bank0_write: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |-> (sw_bank != bank_t'(0) && !enter));
    a_r1_entry_bank_valid: assert property (@(posedge clk) disable iff (!rst_n)
        enter |-> (enter_bank != bank_t'(0)));
    a_r1_saved_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && enter_bank == rd_bank) |=> (rd_saved == $past(enter_status)));

endmodule

// File: rtl/exc_entry_ctrl.sv
// Top of the exception entry controller: status register, entry sequencing,
// software status writes and vector output. Assumes a single clock domain and
// that requests are sampled on every rising edge.
module exc_entry_ctrl
    import exc_ctrl_pkg::*;
#(
    parameter logic [31:0] LOW_BASE  = 32'h0000_0000,
    parameter logic [31:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_reset,
    input  logic        req_undef,
    input  logic        req_swi,
    input  logic        req_pabt,
    input  logic        req_dabt,
    input  logic        req_irq,
    input  logic        req_fiq,
    input  logic [31:0] ret_link,
    input  logic        hivec_sel,
    input  logic        sw_wr_en,
    input  logic        sw_wr_saved,
    input  logic [31:0] sw_wr_data,
    output logic [31:0] status_word,
    output logic [31:0] saved_word,
    output logic        saved_invalid,
    output logic [31:0] mode_link,
    output logic [31:0] new_pc,
    output logic        entry_stb
);

    localparam logic [STATUS_W-1:0] RESET_STATUS =
        STATUS_W'({1'b1, 1'b1, 1'b0, MODE_SVC});

    logic [STATUS_W-1:0] cpsr_q, cpsr_d;
    logic [31:0]         pc_q, vec_addr;
    logic                stb_q;
    logic [NUM_KINDS-1:0] req_vec;
    logic                take;
    exc_kind_e           kind;
    logic [MODE_W-1:0]   cur_mode, tgt_mode;
    bank_t               cur_bank, tgt_bank;
    logic                has_saved, sw_saved_wr;

    // Gather request lines into a vector indexed by kind.
    always_comb begin
        req_vec           = '0;
        req_vec[EK_RESET] = req_reset;
        req_vec[EK_UNDEF] = req_undef;
        req_vec[EK_SWI]   = req_swi;
        req_vec[EK_PABT]  = req_pabt;
        req_vec[EK_DABT]  = req_dabt;
        req_vec[EK_IRQ]   = req_irq;
        req_vec[EK_FIQ]   = req_fiq;
    end

    exc_req_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req_vec),
        .irq_masked (cpsr_q[BIT_I]),
        .fiq_masked (cpsr_q[BIT_F]),
        .grant_vld  (take),
        .grant_kind (kind)
    );

    exc_vector_gen #(
        .AW        (32),
        .LOW_BASE  (LOW_BASE),
        .HIGH_BASE (HIGH_BASE)
    ) u_vec (
        .kind  (kind),
        .hivec (hivec_sel),
        .addr  (vec_addr)
    );

    // Mode decode for the current and target modes.
    always_comb begin
        cur_mode    = cpsr_q[MODE_W-1:0];
        cur_bank    = bank_of(cur_mode);
        has_saved   = (cur_bank != bank_t'(0));
        tgt_mode    = mode_for(kind);
        tgt_bank    = bank_of(tgt_mode);
        sw_saved_wr = sw_wr_en && sw_wr_saved && !take && has_saved;
    end

    // Next status: entry rewrite, else guarded software write.
    always_comb begin
        cpsr_d = cpsr_q;
        if (take) begin
            cpsr_d[MODE_W-1:0] = tgt_mode;
            cpsr_d[BIT_T]      = 1'b0;
            cpsr_d[BIT_I]      = 1'b1;
            if (sets_fiq_mask(kind)) cpsr_d[BIT_F] = 1'b1;
        end else if (sw_wr_en && !sw_wr_saved) begin
            if (cur_mode == MODE_USR) cpsr_d = {sw_wr_data[STATUS_W-1:8], cpsr_q[7:0]};
            else                      cpsr_d = sw_wr_data;
        end
    end

    // Status, vector and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpsr_q <= RESET_STATUS;
            pc_q   <= '0;
            stb_q  <= 1'b0;
        end else begin
            cpsr_q <= cpsr_d;
            stb_q  <= take;
            if (take) pc_q <= vec_addr;
        end
    end

    exc_mode_bank #(
        .W  (STATUS_W),
        .NB (NUM_BANKS)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter        (take),
        .enter_bank   (tgt_bank),
        .enter_status (cpsr_q),
        .enter_link   (ret_link),
        .sw_wr        (sw_saved_wr),
        .sw_bank      (cur_bank),
        .sw_data      (sw_wr_data),
        .rd_bank      (cur_bank),
        .rd_saved     (saved_word),
        .rd_link      (mode_link)
    );

    // Port drive.
    always_comb begin
        status_word   = cpsr_q;
        saved_invalid = !has_saved;
        new_pc        = pc_q;
        entry_stb     = stb_q;
    end

    a_r3_irq_mask_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        entry_stb |-> status_word[BIT_I]);
    a_r2_state_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        entry_stb |-> (!status_word[BIT_T] && !saved_invalid));
    a_r3_fiq_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_stb && new_pc[4:0] != 5'h00 && new_pc[4:0] != 5'h1C)
            |-> (status_word[BIT_F] == $past(status_word[BIT_F])));
    a_r4_vector_shape: assert property (@(posedge clk) disable iff (!rst_n)
        entry_stb |-> (new_pc[1:0] == 2'b00 && new_pc[4:2] != 3'd5
            && new_pc[31:5] == ($past(hivec_sel) ? HIGH_BASE[31:5] : LOW_BASE[31:5])));
    a_r8_user_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && !sw_wr_saved && !take && cur_mode == MODE_USR)
            |=> (status_word[7:0] == $past(status_word[7:0])));
    a_r7_invalid_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        saved_invalid |-> (saved_word == '0));

endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_reset = 0, req_undef = 0, req_swi = 0, req_pabt = 0;
    logic        req_dabt = 0, req_irq = 0, req_fiq = 0;
    logic [31:0] ret_link = '0;
    logic        hivec_sel = 0;
    logic        sw_wr_en = 0, sw_wr_saved = 0;
    logic [31:0] sw_wr_data = '0;
    logic [31:0] status_word, saved_word, mode_link, new_pc;
    logic        saved_invalid, entry_stb;

    int n_vec = 0;
    int n_bad = 0;
    bit run_done = 0;
    bit mon_en = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_reset(req_reset), .req_undef(req_undef), .req_swi(req_swi),
        .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
        .ret_link(ret_link), .hivec_sel(hivec_sel),
        .sw_wr_en(sw_wr_en), .sw_wr_saved(sw_wr_saved), .sw_wr_data(sw_wr_data),
        .status_word(status_word), .saved_word(saved_word), .saved_invalid(saved_invalid),
        .mode_link(mode_link), .new_pc(new_pc), .entry_stb(entry_stb)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cpsr, m_pc;
    logic        m_stb;
    logic [31:0] m_saved [int];
    logic [31:0] m_lnk   [int];

    function automatic int lkey(logic [4:0] m);
        return (m == 5'h1F) ? 16 : int'(m);
    endfunction

    function automatic bit owns_saved(logic [4:0] m);
        return m inside {5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cpsr = 32'h0000_00D3;
            m_pc   = 0;
            m_stb  = 0;
            m_saved.delete();
            m_lnk.delete();
        end else begin
            int k;
            logic [4:0] tm;
            k = -1;
            if (req_reset)                     k = 0;
            else if (req_dabt)                 k = 4;
            else if (req_fiq && !m_cpsr[6])    k = 7;
            else if (req_irq && !m_cpsr[7])    k = 6;
            else if (req_pabt)                 k = 3;
            else if (req_undef)                k = 1;
            else if (req_swi)                  k = 2;
            if (k >= 0) begin
                case (k)
                    7: tm = 5'h11;
                    6: tm = 5'h12;
                    3, 4: tm = 5'h17;
                    1: tm = 5'h1B;
                    default: tm = 5'h13;
                endcase
                m_saved[int'(tm)] = m_cpsr;
                m_lnk[lkey(tm)]   = ret_link;
                m_cpsr[4:0] = tm;
                m_cpsr[5]   = 0;
                if (k == 0 || k == 7) m_cpsr[6] = 1;
                m_cpsr[7]   = 1;
                m_pc  = (hivec_sel ? 32'hFFFF_0000 : 32'h0) + 32'(k * 4);
                m_stb = 1;
            end else begin
                m_stb = 0;
                if (sw_wr_en && !sw_wr_saved) begin
                    if (m_cpsr[4:0] == 5'h10) m_cpsr = {sw_wr_data[31:8], m_cpsr[7:0]};
                    else                      m_cpsr = sw_wr_data;
                end else if (sw_wr_en && owns_saved(m_cpsr[4:0])) begin
                    m_saved[int'(m_cpsr[4:0])] = sw_wr_data;
                end
            end
        end
    end

    function automatic logic [31:0] exp_saved();
        int m = int'(m_cpsr[4:0]);
        if (!owns_saved(m_cpsr[4:0])) return 0;
        return m_saved.exists(m) ? m_saved[m] : 32'h0;
    endfunction

    function automatic logic [31:0] exp_link();
        int m = lkey(m_cpsr[4:0]);
        return m_lnk.exists(m) ? m_lnk[m] : 32'h0;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (mon_en) begin
            chk("R2", "status_word", status_word, m_cpsr);
            chk("R1", "saved_word", saved_word, exp_saved());
            chk("R7", "saved_invalid", 32'(saved_invalid), 32'(!owns_saved(m_cpsr[4:0])));
            chk("R1", "mode_link", mode_link, exp_link());
            chk("R4", "new_pc", new_pc, m_pc);
            chk("R9", "entry_stb", 32'(entry_stb), 32'(m_stb));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        {req_reset, req_undef, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = '0;
        sw_wr_en = 0;
        sw_wr_saved = 0;
    endtask

    task automatic wr_cur(logic [31:0] d);
        sw_wr_en = 1; sw_wr_saved = 0; sw_wr_data = d;
        tick();
        idle_inputs();
    endtask

    task automatic wr_sav(logic [31:0] d);
        sw_wr_en = 1; sw_wr_saved = 1; sw_wr_data = d;
        tick();
        idle_inputs();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!run_done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
        @(negedge clk);
        repeat (3) tick();
        // R9: reset state
        chk("R9", "reset status", status_word, 32'h0000_00D3);
        chk("R9", "reset pc", new_pc, 32'h0);
        chk("R9", "reset strobe", 32'(entry_stb), 32'h0);
        rst_n = 1;
        mon_en = 1;
        tick();

        // R1/R2/R4: software interrupt from reset state
        req_swi = 1; ret_link = 32'h0000_0104;
        tick(); idle_inputs();
        chk("R4", "swi vector", new_pc, 32'h0000_0008);
        chk("R1", "svc saved", saved_word, 32'h0000_00D3);
        chk("R1", "svc link", mode_link, 32'h0000_0104);
        chk("R2", "svc mode", status_word, 32'h0000_00D3);
        chk("R9", "strobe high", 32'(entry_stb), 32'h1);

        // R8: privileged full write, drop to user with masks clear
        wr_cur(32'h0000_0010);
        chk("R8", "privileged write", status_word, 32'h0000_0010);
        // R7: user mode has no saved status; write ignored
        chk("R7", "user invalid", 32'(saved_invalid), 32'h1);
        wr_sav(32'hDEAD_BEEF);
        chk("R7", "user saved read", saved_word, 32'h0);
        // R8: user write keeps control byte
        wr_cur(32'hF000_00D3);
        chk("R8", "user write", status_word, 32'hF000_0010);

        // R3: IRQ keeps FIQ mask clear, sets IRQ mask
        req_irq = 1; ret_link = 32'h0000_1000;
        tick(); idle_inputs();
        chk("R3", "irq entry status", status_word, 32'hF000_0092);
        chk("R4", "irq vector", new_pc, 32'h0000_0018);
        chk("R1", "irq saved", saved_word, 32'hF000_0010);
        // R6: masked IRQ ignored
        req_irq = 1;
        tick(); idle_inputs();
        chk("R6", "masked irq strobe", 32'(entry_stb), 32'h0);
        chk("R6", "masked irq status", status_word, 32'hF000_0092);
        // R3: FIQ sets both masks
        req_fiq = 1; ret_link = 32'h0000_2000;
        tick(); idle_inputs();
        chk("R3", "fiq entry status", status_word, 32'hF000_00D1);
        chk("R4", "fiq vector", new_pc, 32'h0000_001C);
        // R6: masked FIQ ignored
        req_fiq = 1;
        tick(); idle_inputs();
        chk("R6", "masked fiq strobe", 32'(entry_stb), 32'h0);

        // R5/R4: data abort beats the rest, high table
        hivec_sel = 1;
        req_dabt = 1; req_irq = 1; req_pabt = 1; req_undef = 1;
        tick(); idle_inputs();
        chk("R5", "dabt wins", new_pc, 32'hFFFF_0010);
        chk("R2", "abort mode", status_word, 32'hF000_00D7);
        hivec_sel = 0;

        // R7: saved survives ignored write made in system mode
        wr_sav(32'h1234_5678);
        wr_cur(32'h0000_001F);
        chk("R7", "system invalid", 32'(saved_invalid), 32'h1);
        wr_sav(32'hAAAA_5555);
        wr_cur(32'h0000_00D7);
        chk("R7", "abort saved kept", saved_word, 32'h1234_5678);

        // R5: remaining orderings
        req_pabt = 1; req_undef = 1; req_swi = 1;
        tick(); idle_inputs();
        chk("R5", "pabt over undef", new_pc, 32'h0000_000C);
        req_undef = 1; req_swi = 1;
        tick(); idle_inputs();
        chk("R5", "undef over swi", new_pc, 32'h0000_0004);
        req_reset = 1; req_fiq = 1; req_dabt = 1;
        tick(); idle_inputs();
        chk("R5", "reset first", new_pc, 32'h0000_0000);
        chk("R9", "reset entry strobe", 32'(entry_stb), 32'h1);
        // R9: entry wins over write on the same edge
        req_swi = 1; sw_wr_en = 1; sw_wr_data = 32'h0000_0010;
        tick(); idle_inputs();
        chk("R9", "entry beats write", status_word[4:0], 32'h13);
        wr_cur(32'h0000_0010);
        req_fiq = 1; req_irq = 1;
        tick(); idle_inputs();
        chk("R5", "fiq over irq", new_pc, 32'h0000_001C);

        // Mixed random traffic; monitor compares every cycle.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            req_reset = (r[3:0] == 0);
            req_dabt  = (r[7:4] == 1);
            req_pabt  = (r[11:8] == 2);
            req_undef = (r[15:12] == 3);
            req_swi   = (r[19:16] == 4);
            req_irq   = r[20] & r[21];
            req_fiq   = r[22] & r[23] & r[24];
            hivec_sel = r[25];
            sw_wr_en    = r[26];
            sw_wr_saved = r[27];
            sw_wr_data  = {$urandom_range(0, 32'hFF_FFFF) , r[30:28], modes[$urandom_range(0, 6)]};
            ret_link    = $urandom;
            tick();
        end
        idle_inputs();
        tick();

        run_done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule